// File: doc/BRIEF.md
# NOR Flash Buffered Program Engine

This engine programs a short run of words into a parallel NOR flash using the buffered-program command sequence. A requester gives a one-cycle start pulse together with a chip base address, a target address and a word count. It then streams the data words over a valid/ready handshake. The engine issues single-word write and read requests to a flash bus interface. Each request is held until that interface acknowledges it. The engine then judges completion by data polling on the last programmed address and reports the result with a one-cycle done pulse and a status code.

If polling shows a failure, the engine picks one of two recovery sequences and issues it before reporting. Splitting long transfers at buffer boundaries is the requester's job. Physical bus timing belongs to the flash bus interface.

Top module: `nor_bufprog_engine`

## Requirements
- R1: An accepted start first writes 0xAA to base+0xAAA, then 0x55 to base+0x555. Addresses are word addresses, and the base is the chip base input.
- R2: Next, 0x25 is written to the target address, then (word count − 1) is written to the target address.
- R3: Data word i (from 0) is written to target+i. A data word is taken only in the cycle when wr_valid and wr_ready are both high, and wr_ready is high only during the data-load phase.
- R4: After the last data word, 0x29 is written to the target address. No read is requested until more than WAIT_CYC cycles after that write is acknowledged.
- R5: Poll reads always go to target+count−1. A read whose bit 7 equals bit 7 of the last data word ends the operation with status 0 (success).
- R6: If a poll read misses on bit 7 and has bit 5 or bit 1 set, exactly one more read is made. A bit 7 match on that read gives status 0.
- R7: If that extra read misses and has bit 1 set, the engine writes 0xAA to base+0xAAA, 0x55 to base+0x555, then 0xF0 to base+0xAAA. It then reports status 3.
- R8: Any other failure writes a single 0xF0 to the base address and reports status 2.
- R9: Once TIMEOUT_CYC polling cycles have passed, the next poll read that misses without bit 5 or bit 1 set is a failure (handled as in R8). A read that matches still succeeds, even after the timeout.
- R10: A start with a word count of 0 or above BUF_WORDS makes no bus request. Done pulses in the next cycle with status 1.
- R11: Busy rises only in the cycle after an accepted start and falls right after done. Done is one cycle wide. A start while busy is ignored.
- R12: Once raised, a bus request keeps its address, direction and write data stable until the cycle in which it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| base_addr | input | AW | Chip base word address |
| tgt_addr | input | AW | First word address to program |
| word_cnt | input | CW | Number of words to program |
| wr_data | input | DW | Data stream word |
| wr_valid | input | 1 | Data stream word present |
| wr_ready | output | 1 | Data stream word taken this cycle |
| bus_req | output | 1 | Flash bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Flash bus word address |
| bus_wdata | output | DW | Flash bus write data |
| bus_ack | input | 1 | Flash bus request completed (read data valid) |
| bus_rdata | input | DW | Flash bus read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 bad count, 2 failed, 3 aborted |

## Verification
The timeout expiring and a poll read completing can fall in the same cycle. This matters because the timeout must not override a read that actually matches. The bench provokes it by stretching the read latency of the flash model beyond TIMEOUT_CYC, so the first poll acknowledge arrives after the timeout has passed. With a bit 7 match the operation must still report status 0 with no recovery writes. With a plain miss it must report status 2 and issue the single reset write.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_BCMD, S_BCNT, S_LOAD, S_CONF, S_WAIT,
    S_POLL, S_RECHK, S_ABT1, S_ABT2, S_ABT3, S_RST1, S_DONE
  } nbp_state_e;

  localparam logic [1:0] ST_OK     = 2'd0;
  localparam logic [1:0] ST_BADCNT = 2'd1;
  localparam logic [1:0] ST_FAIL   = 2'd2;
  localparam logic [1:0] ST_ABORT  = 2'd3;

  localparam logic [7:0] CMD_UNLK1   = 8'hAA;
  localparam logic [7:0] CMD_UNLK2   = 8'h55;
  localparam logic [7:0] CMD_LOADBUF = 8'h25;
  localparam logic [7:0] CMD_CONFIRM = 8'h29;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
endpackage

// File: rtl/nbp_timer.sv
module nbp_timer #(
  parameter int WAIT_CYC    = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_wait,
  input  logic in_poll,
  output logic wait_done,
  output logic tmo_hit
);
  localparam int WW = $clog2(WAIT_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [WW-1:0] wait_q, wait_d;
  logic [TW-1:0] tmo_q, tmo_d;

  assign wait_done = in_wait && (wait_q == WW'(WAIT_CYC - 1));
  assign tmo_hit   = (tmo_q == TW'(TIMEOUT_CYC));

  always_comb begin
    wait_d = in_wait ? wait_q + WW'(1) : '0;
    if (!in_poll)     tmo_d = '0;
    else if (tmo_hit) tmo_d = tmo_q;
    else              tmo_d = tmo_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      tmo_q  <= '0;
    end else begin
      wait_q <= wait_d;
      tmo_q  <= tmo_d;
    end
  end
endmodule

// File: rtl/nbp_dpath.sv
module nbp_dpath
  import nbp_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 16,
  parameter int CW         = 6,
  parameter int BUF_WORDS  = 16,
  parameter int UNLK_OFS_A = 'hAAA,
  parameter int UNLK_OFS_B = 'h555
) (
  input  logic            clk,
  input  logic            rst_n,
  input  nbp_state_e      state,
  input  logic            start,
  input  logic [AW-1:0]   base_addr,
  input  logic [AW-1:0]   tgt_addr,
  input  logic [CW-1:0]   word_cnt,
  input  logic [DW-1:0]   wr_data,
  input  logic            wr_valid,
  input  logic            bus_ack,
  input  logic [DW-1:0]   bus_rdata,
  output logic            cnt_ok,
  output logic            last_word,
  output logic            rd_match,
  output logic            rd_flag,
  output logic            rd_abort,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            wr_ready
);
  logic [AW-1:0] base_q, tgt_q, last_addr;
  logic [CW-1:0] cnt_q, idx_q;
  logic          d7_q;
  logic          cap_en, load_take;
  logic          unused_rd;

  assign cap_en    = (state == S_IDLE) && start;
  assign load_take = (state == S_LOAD) && bus_ack;

  assign cnt_ok    = (word_cnt != '0) && (word_cnt <= CW'(BUF_WORDS));
  assign last_word = (idx_q == cnt_q - CW'(1));
  assign last_addr = tgt_q + AW'(cnt_q) - AW'(1);

  assign rd_match  = (bus_rdata[7] == d7_q);
  assign rd_flag   = bus_rdata[5] | bus_rdata[1];
  assign rd_abort  = bus_rdata[1];
  assign unused_rd = ^{bus_rdata[DW-1:8], bus_rdata[6], bus_rdata[4:2], bus_rdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
    end else if (cap_en) begin
      base_q <= base_addr;
      tgt_q  <= tgt_addr;
      cnt_q  <= word_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      d7_q  <= 1'b0;
    end else if (cap_en) begin
      idx_q <= '0;
    end else if (load_take) begin
      idx_q <= idx_q + CW'(1);
      d7_q  <= wr_data[7];
    end
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b1;
    bus_addr  = base_q;
    bus_wdata = '0;
    wr_ready  = 1'b0;
    case (state)
      S_UNL1, S_ABT1: begin
        bus_req = 1'b1; bus_addr = base_q + AW'(UNLK_OFS_A); bus_wdata = DW'(CMD_UNLK1);
      end
      S_UNL2, S_ABT2: begin
        bus_req = 1'b1; bus_addr = base_q + AW'(UNLK_OFS_B); bus_wdata = DW'(CMD_UNLK2);
      end
      S_BCMD: begin
        bus_req = 1'b1; bus_addr = tgt_q; bus_wdata = DW'(CMD_LOADBUF);
      end
      S_BCNT: begin
        bus_req = 1'b1; bus_addr = tgt_q; bus_wdata = DW'(cnt_q - CW'(1));
      end
      S_LOAD: begin
        bus_req   = wr_valid;
        bus_addr  = tgt_q + AW'(idx_q);
        bus_wdata = wr_data;
        wr_ready  = bus_ack;
      end
      S_CONF: begin
        bus_req = 1'b1; bus_addr = tgt_q; bus_wdata = DW'(CMD_CONFIRM);
      end
      S_POLL, S_RECHK: begin
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = last_addr;
      end
      S_ABT3: begin
        bus_req = 1'b1; bus_addr = base_q + AW'(UNLK_OFS_A); bus_wdata = DW'(CMD_RESET);
      end
      S_RST1: begin
        bus_req = 1'b1; bus_addr = base_q; bus_wdata = DW'(CMD_RESET);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nbp_ctrl.sv
module nbp_ctrl
  import nbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cnt_ok,
  input  logic       bus_ack,
  input  logic       last_word,
  input  logic       wait_done,
  input  logic       tmo_hit,
  input  logic       rd_match,
  input  logic       rd_flag,
  input  logic       rd_abort,
  output nbp_state_e state_q,
  output logic [1:0] status_q
);
  nbp_state_e state_d;
  logic [1:0] status_d;

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    case (state_q)
      S_IDLE: if (start) begin
        if (cnt_ok) begin state_d = S_UNL1; status_d = ST_OK; end
        else        begin state_d = S_DONE; status_d = ST_BADCNT; end
      end
      S_UNL1: if (bus_ack) state_d = S_UNL2;
      S_UNL2: if (bus_ack) state_d = S_BCMD;
      S_BCMD: if (bus_ack) state_d = S_BCNT;
      S_BCNT: if (bus_ack) state_d = S_LOAD;
      S_LOAD: if (bus_ack && last_word) state_d = S_CONF;
      S_CONF: if (bus_ack) state_d = S_WAIT;
      S_WAIT: if (wait_done) state_d = S_POLL;
      S_POLL: if (bus_ack) begin
        if (rd_match)     begin state_d = S_DONE; status_d = ST_OK; end
        else if (rd_flag) state_d = S_RECHK;
        else if (tmo_hit) begin state_d = S_RST1; status_d = ST_FAIL; end
      end
      S_RECHK: if (bus_ack) begin
        if (rd_match)      begin state_d = S_DONE; status_d = ST_OK; end
        else if (rd_abort) begin state_d = S_ABT1; status_d = ST_ABORT; end
        else               begin state_d = S_RST1; status_d = ST_FAIL; end
      end
      S_ABT1: if (bus_ack) state_d = S_ABT2;
      S_ABT2: if (bus_ack) state_d = S_ABT3;
      S_ABT3: if (bus_ack) state_d = S_DONE;
      S_RST1: if (bus_ack) state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/nor_bufprog_engine.sv
module nor_bufprog_engine
  import nbp_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int CW          = 6,
  parameter int BUF_WORDS   = 16,
  parameter int WAIT_CYC    = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] tgt_addr,
  input  logic [CW-1:0] word_cnt,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status
);
  nbp_state_e state;
  logic cnt_ok, last_word, rd_match, rd_flag, rd_abort, wait_done, tmo_hit;

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  nbp_ctrl u_ctrl (
    .clk, .rst_n, .start, .cnt_ok, .bus_ack, .last_word, .wait_done,
    .tmo_hit, .rd_match, .rd_flag, .rd_abort,
    .state_q(state), .status_q(status)
  );

  nbp_dpath #(.AW(AW), .DW(DW), .CW(CW), .BUF_WORDS(BUF_WORDS)) u_dpath (
    .clk, .rst_n, .state, .start, .base_addr, .tgt_addr, .word_cnt,
    .wr_data, .wr_valid, .bus_ack, .bus_rdata, .cnt_ok, .last_word,
    .rd_match, .rd_flag, .rd_abort, .bus_req, .bus_we, .bus_addr,
    .bus_wdata, .wr_ready
  );

  nbp_timer #(.WAIT_CYC(WAIT_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk, .rst_n,
    .in_wait(state == S_WAIT),
    .in_poll((state == S_POLL) || (state == S_RECHK)),
    .wait_done, .tmo_hit
  );
endmodule

// File: rtl/nbp_checker.sv
module nbp_checker #(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int CW        = 6,
  parameter int BUF_WORDS = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] word_cnt,
  input logic          busy,
  input logic          done,
  input logic [1:0]    status,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          wr_ready
);
  p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (word_cnt == '0 || word_cnt > CW'(BUF_WORDS)) |=> done && status == 2'd1);

  p_busy_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_done_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy ##1 (!busy && !done));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_ready_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> bus_req && bus_we && bus_ack && busy);
endmodule

bind nor_bufprog_engine nbp_checker #(.AW(AW), .DW(DW), .CW(CW), .BUF_WORDS(BUF_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .word_cnt(word_cnt), .busy(busy),
  .done(done), .status(status), .bus_req(bus_req), .bus_we(bus_we),
  .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wr_ready(wr_ready)
);

// File: tb/tb_nor_bufprog_engine.sv
module tb_nor_bufprog_engine;
  localparam int AW = 24, DW = 16, CW = 6, BUFW = 16, WAITC = 8, TMOC = 64;
  localparam int M_OKN = 0, M_B5OK = 1, M_B5F = 2, M_B1F = 3, M_TMO = 4,
                 M_SLOW = 5, M_SLOWMISS = 6, M_REJ = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base_addr = '0, tgt_addr = '0;
  logic [CW-1:0] word_cnt = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_valid = 1'b0;
  logic wr_ready, bus_req, bus_we, busy, done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ack;
  logic [DW-1:0] bus_rdata;
  logic [1:0] status;

  always #4 clk = ~clk;

  nor_bufprog_engine #(.AW(AW), .DW(DW), .CW(CW), .BUF_WORDS(BUFW),
    .WAIT_CYC(WAITC), .TIMEOUT_CYC(TMOC)) dut (.*);

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // test context
  int mode, nbusy, wlat, rlat, tcnt;
  logic d7;
  logic [DW-1:0] data_q [64];
  logic [AW-1:0] wl_a [64]; logic [DW-1:0] wl_d [64]; int wl_t [64]; int wl_n;
  logic [AW-1:0] rl_a [512]; int rl_n; int r_t0_first; int viol;

  function automatic logic [DW-1:0] resp(input int m, input int ridx, input logic b7d, input int nb);
    logic b7, b5, b1;
    b7 = ~b7d; b5 = 1'b0; b1 = 1'b0;
    case (m)
      M_OKN:  b7 = (ridx >= nb) ? b7d : ~b7d;
      M_B5OK: begin b7 = (ridx >= 1) ? b7d : ~b7d; b5 = (ridx == 0); end
      M_B5F:  b5 = 1'b1;
      M_B1F:  b1 = 1'b1;
      M_SLOW: b7 = b7d;
      default: ;
    endcase
    return {8'h00, b7, 1'b0, b5, 3'b000, b1, 1'b0};
  endfunction

  // flash bus model
  logic m_pend; int m_cnt, m_t0; logic [AW-1:0] m_a; logic m_we; logic [DW-1:0] m_d;
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; bus_rdata <= '0; m_pend <= 1'b0; m_cnt <= 0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0; m_pend <= 1'b0;
      if (bus_we) begin
        if (wl_n < 64) begin wl_a[wl_n] = bus_addr; wl_d[wl_n] = bus_wdata; wl_t[wl_n] = cyc; end
        wl_n++;
      end else begin
        if (rl_n == 0) r_t0_first = m_t0;
        if (rl_n < 512) rl_a[rl_n] = bus_addr;
        rl_n++;
      end
    end else if (bus_req) begin
      int c;
      if (m_pend && (bus_addr != m_a || bus_we != m_we || bus_wdata != m_d)) viol++;
      if (!m_pend) begin m_t0 <= cyc; m_a <= bus_addr; m_we <= bus_we; m_d <= bus_wdata; end
      m_pend <= 1'b1;
      c = m_pend ? m_cnt : 0;
      if (c >= (bus_we ? wlat : rlat)) begin
        bus_ack <= 1'b1;
        if (!bus_we) bus_rdata <= resp(mode, rl_n, d7, nbusy);
      end else m_cnt <= c + 1;
    end else if (m_pend) viol++;
  end

  task automatic run_test(input int m, input int cnt, input int wl, input int rl,
                          input int nb, input bit poke);
    logic [AW-1:0] ea [64]; logic [DW-1:0] ed [64]; int en;
    logic [AW-1:0] b, t;
    int exp_st, exp_rd, idx, acc, done_n, done_at, busy_after, k, st_seen, vcnt;
    bit hs, gap, seen;
    mode = m; nbusy = nb; wlat = wl; rlat = rl; tcnt = cnt;
    wl_n = 0; rl_n = 0; viol = 0; r_t0_first = 0;
    b = AW'($urandom) & 24'hFF0000; t = b + AW'($urandom % 'h8000) + 24'h1000;
    for (int i = 0; i < 64; i++) data_q[i] = DW'($urandom);
    d7 = (cnt > 0 && cnt <= 64) ? data_q[cnt-1][7] : 1'b0;
    // expected writes
    en = 0;
    if (m != M_REJ) begin
      ea[0] = b + 24'hAAA; ed[0] = 16'hAA; ea[1] = b + 24'h555; ed[1] = 16'h55;
      ea[2] = t; ed[2] = 16'h25; ea[3] = t; ed[3] = DW'(cnt - 1); en = 4;
      for (int i = 0; i < cnt; i++) begin ea[en] = t + AW'(i); ed[en] = data_q[i]; en++; end
      ea[en] = t; ed[en] = 16'h29; en++;
      if (m == M_B1F) begin
        ea[en] = b + 24'hAAA; ed[en] = 16'hAA; en++;
        ea[en] = b + 24'h555; ed[en] = 16'h55; en++;
        ea[en] = b + 24'hAAA; ed[en] = 16'hF0; en++;
      end else if (m == M_B5F || m == M_TMO || m == M_SLOWMISS) begin
        ea[en] = b; ed[en] = 16'hF0; en++;
      end
    end
    case (m)
      M_OKN, M_B5OK, M_SLOW: exp_st = 0;
      M_B1F: exp_st = 3;
      M_REJ: exp_st = 1;
      default: exp_st = 2;
    endcase
    case (m)
      M_OKN: exp_rd = nb + 1;
      M_B5OK, M_B5F, M_B1F: exp_rd = 2;
      M_SLOW, M_SLOWMISS: exp_rd = 1;
      M_REJ: exp_rd = 0;
      default: exp_rd = -1;
    endcase
    vcnt = (m == M_REJ) ? 1 : cnt;
    // launch
    @(negedge clk);
    base_addr = b; tgt_addr = t; word_cnt = CW'(cnt); start = 1'b1;
    idx = 0; acc = 0; hs = 0; gap = 0;
    wr_valid = 1'b1; wr_data = data_q[0];
    done_n = 0; done_at = -1; busy_after = 0; seen = 0; st_seen = -1;
    for (k = 1; k < 6000; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == 1) check(busy == 1'b1 || m == M_REJ, "R11 busy after start", busy, 1);
      if (poke && k == 20) begin start = 1'b1; word_cnt = '0; end
      if (poke && k == 21) word_cnt = CW'(cnt);
      if (hs) begin idx++; acc++; gap = ($urandom % 4) == 0; end
      else gap = 1'b0;
      wr_valid = (idx < vcnt) && !gap;
      wr_data = data_q[idx < 64 ? idx : 0];
      hs = wr_valid && wr_ready;
      if (seen) begin busy_after = busy; break; end
      if (done) begin
        done_n++; if (done_at < 0) done_at = k; st_seen = status;
        seen = 1;
      end
    end
    @(negedge clk);
    if (done) done_n++;
    wr_valid = 1'b0;
    check(done_n == 1, "R11 done single pulse", done_n, 1);
    check(busy_after == 0, "R11 busy low after done", busy_after, 0);
    if (m == M_REJ) begin
      check(done_at == 1, "R10 done next cycle", done_at, 1);
      check(acc == 0, "R10 no data taken", acc, 0);
    end else
      check(acc == cnt, "R3 words taken", acc, cnt);
    check(st_seen == exp_st, (exp_st == 3) ? "R7 status" : (exp_st == 2) ? "R8 status" :
          (exp_st == 1) ? "R10 status" : "R5 status", st_seen, exp_st);
    check(wl_n == en, "R1 write count", wl_n, en);
    for (int i = 0; i < en && i < wl_n; i++) begin
      string r;
      r = (i < 2) ? "R1 write" : (i < 4) ? "R2 write" : (i < 4 + cnt) ? "R3 write" :
          (i == 4 + cnt) ? "R4 write" : (m == M_B1F) ? "R7 write" : "R8 write";
      check(wl_a[i] == ea[i] && wl_d[i] == ed[i], r, {wl_a[i], wl_d[i]}, {ea[i], ed[i]});
    end
    if (exp_rd >= 0)
      check(rl_n == exp_rd, (m == M_OKN) ? "R5 read count" : (m >= M_SLOW) ? "R9 read count" : "R6 read count", rl_n, exp_rd);
    else
      check(rl_n >= 2, "R9 reads before timeout", rl_n, 2);
    for (int i = 0; i < rl_n && i < 512; i++)
      if (rl_a[i] != t + AW'(cnt) - AW'(1)) begin
        check(0, "R5 read address", rl_a[i], t + AW'(cnt) - AW'(1)); break;
      end
    if (m != M_REJ && wl_n > 4 + cnt)
      check(r_t0_first - wl_t[4+cnt] > WAITC, "R4 wait before poll", r_t0_first - wl_t[4+cnt], WAITC + 1);
    check(viol == 0, "R12 request held", viol, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && bus_req == 0 && wr_ready == 0, "R11 reset state",
          {busy, done, bus_req, wr_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_test(M_REJ, 0, 0, 0, 0, 0);
    run_test(M_REJ, BUFW + 1, 0, 0, 0, 0);
    run_test(M_OKN, 1, 0, 0, 0, 0);
    run_test(M_OKN, BUFW, 1, 0, 2, 1);
    run_test(M_B5OK, 3, 0, 1, 0, 0);
    run_test(M_B5F, 4, 2, 0, 0, 0);
    run_test(M_B1F, 2, 0, 2, 0, 0);
    run_test(M_TMO, 5, 0, 1, 0, 0);
    run_test(M_SLOW, 3, 0, TMOC + 4, 0, 0);
    run_test(M_SLOWMISS, 3, 0, TMOC + 4, 0, 0);
    // random mix
    for (int n = 0; n < 24; n++)
      run_test(int'($urandom % 5), 1 + int'($urandom % BUFW), int'($urandom % 3),
               int'($urandom % 3), int'($urandom % 4), ($urandom % 3) == 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule